// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recently used virtual-to-physical page mappings. The processor presents a virtual address with an access type (read, write or instruction fetch). The virtual page number is compared against the tag of every entry at once. A matching valid entry whose permission covers the access returns the physical address in the same cycle. That address is the stored physical page number joined to the untouched page offset, together with the entry's dirty bit.

When no entry matches, the block raises a miss. An external page-table walker then supplies the mapping through the fill port, and the requester retries the lookup, which then hits. Software keeps the contents coherent. A write to the page-table base register flushes every entry, and an invalidate carrying a virtual page number removes that one mapping. The block never writes anything back toward the page tables.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A lookup whose page number equals the tag of a valid entry, with the permission present, raises `lk_hit` in the same cycle. `lk_paddr` is then the entry's physical page number in the upper bits and the request's offset in the low `PAGE_BITS` bits. Without a hit, `lk_paddr` and `lk_dirty` are zero.
- R3: A lookup with no matching valid entry raises `lk_miss`. After a fill with that page number, a retry of the same lookup hits.
- R4: Access code 1 (write) needs the write bit, code 2 (fetch) needs the execute bit, and codes 0 and 3 (read) need the read bit. A matching entry without the needed bit raises `lk_fault` instead of `lk_hit`.
- R5: On a hit, `lk_dirty` equals the dirty bit stored for that entry.
- R6: A cycle with `ptbr_wr` high invalidates every entry from the next cycle on.
- R7: An invalidate clears only the valid entry whose tag equals `inv_vpn`. With no such entry, nothing changes.
- R8: A fill whose page number is already held overwrites that entry. Otherwise it takes the lowest-indexed invalid entry.
- R9: A fill into a full block replaces the least recently used entry. A lookup that matches an entry (hit or fault) and a fill both make the touched entry the most recently used.
- R10: When `ptbr_wr` and `fill_valid` are high in the same cycle, the fill is discarded.
- R11: Lookups never change stored entries. A write hit on a clean page leaves its dirty bit clear. Only fill, invalidate and flush alter the contents.
- R12: While `lk_valid` is high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. While it is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching valid entry |
| lk_fault | output | 1 | Entry found but access not permitted |
| lk_paddr | output | PA_W | Translated physical address |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| fill_valid | input | 1 | Mapping supplied by the walker |
| fill_vpn | input | VA_W-PAGE_BITS | Virtual page number of the fill |
| fill_ppn | input | PA_W-PAGE_BITS | Physical page number of the fill |
| fill_r | input | 1 | Read permission of the fill |
| fill_w | input | 1 | Write permission of the fill |
| fill_x | input | 1 | Execute permission of the fill |
| fill_d | input | 1 | Dirty bit of the fill |
| inv_valid | input | 1 | Invalidate one mapping |
| inv_vpn | input | VA_W-PAGE_BITS | Virtual page number to invalidate |
| ptbr_wr | input | 1 | Page-table base register written; flush all |

## Verification
The bench builds the block with 4 entries, 4-bit page offsets and 12-bit virtual and physical addresses, which gives 256 virtual pages. With that configuration every sweep can look up each virtual page and compare the result with a reference table in the bench. Four entries let a handful of fills reach the full-block replacement path, so the order of least recent use is checked after mixed hits, faults and fills. All 16 combinations of permission and dirty bits are crossed with all four access codes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RD2 = 2'd3
   } acc_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
      logic d;
   } perm_t;

endpackage

// File: rtl/tlb_prio.sv
// Lowest-index-wins priority encoder.
module tlb_prio #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tlb_lru.sv
// Exact recency order kept as per-entry ages forming a permutation.
module tlb_lru #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] lru_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] age_q [ENTRIES];
   logic [ENTRIES-1:0] oldest_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_old
      assign oldest_vec[g] = (age_q[g] == OLDEST);
   end

   tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_old_enc (
      .req (oldest_vec),
      .idx (lru_idx),
      .any ()
   );

   // R9
   touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> age_q[$past(touch_idx)] == '0);

   // R9
   oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest_vec));
endmodule

// File: rtl/tlb_store.sv
// Entry array with parallel tag compare for lookup, fill and invalidate.
module tlb_store
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               inv_en,
   input  logic [VPN_W-1:0]   inv_vpn,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  perm_t              wr_perm,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [VPN_W-1:0]   fl_vpn,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] fl_match,
   output logic [ENTRIES-1:0] valid_o,
   output logic [PPN_W-1:0]   rd_ppn,
   output perm_t              rd_perm
);
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] inv_match;
   logic [VPN_W-1:0]   tag_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   perm_t              perm_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g]  = valid_q[g] && (tag_q[g] == lk_vpn);
      assign fl_match[g]  = valid_q[g] && (tag_q[g] == fl_vpn);
      assign inv_match[g] = valid_q[g] && (tag_q[g] == inv_vpn);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else begin
         if (inv_en) valid_q <= valid_q & ~inv_match;
         if (wr_en)  valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_vpn;
         ppn_q[wr_idx]  <= wr_ppn;
         perm_q[wr_idx] <= wr_perm;
      end
   end

   assign valid_o = valid_q;
   assign rd_ppn  = ppn_q[rd_idx];
   assign rd_perm = perm_q[rd_idx];

   // R6
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_q == '0);

   // R8
   fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]);

   // R7
   inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && !flush && !wr_en) |=>
         $countones(valid_q) == $countones($past(valid_q)) - $countones($past(inv_match)));

   // R8
   tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_pkg::*;
#(
   parameter int ENTRIES   = 64,
   parameter int PAGE_BITS = 12,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lk_valid,
   input  logic [VA_W-1:0]           lk_vaddr,
   input  logic [1:0]                lk_acc,
   output logic                      lk_hit,
   output logic                      lk_miss,
   output logic                      lk_fault,
   output logic [PA_W-1:0]           lk_paddr,
   output logic                      lk_dirty,
   input  logic                      fill_valid,
   input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input  logic                      fill_r,
   input  logic                      fill_w,
   input  logic                      fill_x,
   input  logic                      fill_d,
   input  logic                      inv_valid,
   input  logic [VA_W-PAGE_BITS-1:0] inv_vpn,
   input  logic                      ptbr_wr
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must be at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_fa: PAGE_BITS must leave a page number in both address widths");
   end

   logic [VPN_W-1:0]     lk_vpn;
   logic [PAGE_BITS-1:0] lk_off;
   logic [ENTRIES-1:0]   lk_match, fl_match, valid_vec;
   logic [IDX_W-1:0]     lk_idx, fl_idx, free_idx, lru_idx, wr_idx, touch_idx;
   logic                 lk_any, fl_any, free_any, wr_en, touch_en, perm_ok;
   logic [PPN_W-1:0]     rd_ppn;
   perm_t                rd_perm;
   perm_t                wr_perm;
   acc_e                 acc;

   assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_BITS];
   assign lk_off  = lk_vaddr[PAGE_BITS-1:0];
   assign acc     = acc_e'(lk_acc);
   assign wr_perm = '{r: fill_r, w: fill_w, x: fill_x, d: fill_d};
   assign wr_en   = fill_valid && !ptbr_wr;

   tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ptbr_wr),
      .inv_en   (inv_valid),
      .inv_vpn  (inv_vpn),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_vpn   (fill_vpn),
      .wr_ppn   (fill_ppn),
      .wr_perm  (wr_perm),
      .lk_vpn   (lk_vpn),
      .fl_vpn   (fill_vpn),
      .rd_idx   (lk_idx),
      .lk_match (lk_match),
      .fl_match (fl_match),
      .valid_o  (valid_vec),
      .rd_ppn   (rd_ppn),
      .rd_perm  (rd_perm)
   );

   tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
      .req (lk_match), .idx (lk_idx), .any (lk_any));

   tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_fl_enc (
      .req (fl_match), .idx (fl_idx), .any (fl_any));

   tlb_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
      .req (~valid_vec), .idx (free_idx), .any (free_any));

   tlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .lru_idx   (lru_idx)
   );

   // Victim order: same page already held, then lowest free slot, then oldest.
   always_comb begin
      if (fl_any)        wr_idx = fl_idx;
      else if (free_any) wr_idx = free_idx;
      else               wr_idx = lru_idx;
   end

   assign touch_en  = wr_en || (lk_valid && lk_any);
   assign touch_idx = wr_en ? wr_idx : lk_idx;

   always_comb begin
      unique case (acc)
         ACC_WR:  perm_ok = rd_perm.w;
         ACC_EX:  perm_ok = rd_perm.x;
         default: perm_ok = rd_perm.r;
      endcase
   end

   assign lk_hit   = lk_valid && lk_any && perm_ok;
   assign lk_fault = lk_valid && lk_any && !perm_ok;
   assign lk_miss  = lk_valid && !lk_any;
   assign lk_paddr = lk_hit ? {rd_ppn, lk_off} : '0;
   assign lk_dirty = lk_hit && rd_perm.d;

   // R12
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
endmodule

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
   localparam int ENT = 4;
   localparam int PB  = 4;
   localparam int VAW = 12;
   localparam int PAW = 12;
   localparam int VW  = VAW - PB;
   localparam int PW  = PAW - PB;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           lk_valid = 1'b0;
   logic [VAW-1:0] lk_vaddr = '0;
   logic [1:0]     lk_acc = '0;
   logic           lk_hit, lk_miss, lk_fault, lk_dirty;
   logic [PAW-1:0] lk_paddr;
   logic           fill_valid = 1'b0;
   logic [VW-1:0]  fill_vpn = '0;
   logic [PW-1:0]  fill_ppn = '0;
   logic           fill_r = 1'b0, fill_w = 1'b0, fill_x = 1'b0, fill_d = 1'b0;
   logic           inv_valid = 1'b0;
   logic [VW-1:0]  inv_vpn = '0;
   logic           ptbr_wr = 1'b0;

   always #2 clk = ~clk;

   tlb_fa #(.ENTRIES(ENT), .PAGE_BITS(PB), .VA_W(VAW), .PA_W(PAW)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_acc (lk_acc),
      .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_fault (lk_fault),
      .lk_paddr (lk_paddr), .lk_dirty (lk_dirty),
      .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_ppn (fill_ppn),
      .fill_r (fill_r), .fill_w (fill_w), .fill_x (fill_x), .fill_d (fill_d),
      .inv_valid (inv_valid), .inv_vpn (inv_vpn), .ptbr_wr (ptbr_wr)
   );

   // Reference table: perm nibble is {r, w, x, d}.
   bit            mv    [ENT];
   logic [VW-1:0] mvpn  [ENT];
   logic [PW-1:0] mppn  [ENT];
   logic [3:0]    mperm [ENT];
   int            mstamp[ENT];
   int            tnow = 0;
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   function automatic int mfind(logic [VW-1:0] v);
      for (int i = 0; i < ENT; i++) if (mv[i] && mvpn[i] == v) return i;
      return -1;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic look(logic [VW-1:0] vpn, logic [PB-1:0] off, logic [1:0] acc, string tag);
      int  k;
      bit  ok;
      bit  eh, em, ef;
      @(negedge clk);
      lk_valid = 1'b1;
      lk_vaddr = {vpn, off};
      lk_acc   = acc;
      #1;
      k  = mfind(vpn);
      ok = 1'b0;
      if (k >= 0) begin
         case (acc)
            2'd1:    ok = mperm[k][2];
            2'd2:    ok = mperm[k][1];
            default: ok = mperm[k][3];
         endcase
      end
      eh = (k >= 0) && ok;
      ef = (k >= 0) && !ok;
      em = (k < 0);
      chk(tag, {31'd0, lk_hit}, {31'd0, eh});
      chk(tag, {31'd0, lk_miss}, {31'd0, em});
      chk(tag, {31'd0, lk_fault}, {31'd0, ef});
      chk(tag, {20'd0, lk_paddr}, eh ? {20'd0, mppn[k], off} : 32'd0);
      chk(tag, {31'd0, lk_dirty}, eh ? {31'd0, mperm[k][0]} : 32'd0);
      chk("R12", {31'd0, ($countones({lk_hit, lk_miss, lk_fault}) == 1)}, 32'd1);
      @(posedge clk);
      if (k >= 0) begin
         tnow++;
         mstamp[k] = tnow;
      end
      #1 lk_valid = 1'b0;
   endtask

   task automatic fill(logic [VW-1:0] vpn, logic [PW-1:0] ppn, logic [3:0] perm, bit with_flush);
      int k;
      @(negedge clk);
      fill_valid = 1'b1;
      fill_vpn   = vpn;
      fill_ppn   = ppn;
      {fill_r, fill_w, fill_x, fill_d} = perm;
      ptbr_wr    = with_flush;
      @(posedge clk);
      if (with_flush) begin
         for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
      end else begin
         k = mfind(vpn);
         if (k < 0) for (int i = ENT - 1; i >= 0; i--) if (!mv[i]) k = i;
         if (k < 0) begin
            k = 0;
            for (int i = 1; i < ENT; i++) if (mstamp[i] < mstamp[k]) k = i;
         end
         mv[k] = 1'b1; mvpn[k] = vpn; mppn[k] = ppn; mperm[k] = perm;
         tnow++;
         mstamp[k] = tnow;
      end
      #1;
      fill_valid = 1'b0;
      ptbr_wr    = 1'b0;
   endtask

   task automatic flush_all();
      @(negedge clk);
      ptbr_wr = 1'b1;
      @(posedge clk);
      for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
      #1 ptbr_wr = 1'b0;
   endtask

   task automatic inval(logic [VW-1:0] vpn);
      int k;
      @(negedge clk);
      inv_valid = 1'b1;
      inv_vpn   = vpn;
      @(posedge clk);
      k = mfind(vpn);
      if (k >= 0) mv[k] = 1'b0;
      #1 inv_valid = 1'b0;
   endtask

   task automatic sweep(string tag);
      for (int v = 0; v < (1 << VW); v++) look(VW'(v), PB'(v * 7), 2'd0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin mv[i] = 1'b0; mstamp[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: idle outputs quiet
      @(negedge clk);
      chk("R12", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);

      // R1: every page misses after reset
      sweep("R1");

      // R3: miss, fill, retry hits
      look(8'h3c, 4'h5, 2'd0, "R3");
      fill(8'h3c, 8'ha1, 4'b1000, 1'b0);
      look(8'h3c, 4'h5, 2'd0, "R3");

      // R2: full set, every page and offset mix
      fill(8'h00, 8'h5a, 4'b1001, 1'b0);
      fill(8'hff, 8'h0f, 4'b1000, 1'b0);
      fill(8'h81, 8'hc3, 4'b1001, 1'b0);
      sweep("R2");

      // R8: refill of a held page overwrites it in place
      fill(8'hff, 8'h77, 4'b1001, 1'b0);
      look(8'hff, 4'hf, 2'd0, "R8");
      sweep("R8");

      // R9: replacement follows recency
      flush_all();
      fill(8'h10, 8'h01, 4'b1000, 1'b0);
      fill(8'h11, 8'h02, 4'b1000, 1'b0);
      fill(8'h12, 8'h03, 4'b1000, 1'b0);
      fill(8'h13, 8'h04, 4'b1000, 1'b0);
      look(8'h10, 4'h1, 2'd0, "R9");
      look(8'h11, 4'h2, 2'd1, "R9");
      fill(8'h14, 8'h05, 4'b1000, 1'b0);
      look(8'h12, 4'h3, 2'd0, "R9");
      look(8'h13, 4'h4, 2'd0, "R9");
      fill(8'h15, 8'h06, 4'b1000, 1'b0);
      sweep("R9");

      // R7: invalidate a present page, then an absent one
      inval(8'h13);
      sweep("R7");
      inval(8'hee);
      sweep("R7");

      // R8: freed slot is reused before any eviction
      fill(8'h20, 8'h99, 4'b1000, 1'b0);
      sweep("R8");

      // R6: flush empties the block
      flush_all();
      sweep("R6");

      // R10: fill in the flush cycle is dropped
      fill(8'h30, 8'h31, 4'b1000, 1'b0);
      fill(8'h40, 8'h41, 4'b1000, 1'b1);
      look(8'h40, 4'h0, 2'd0, "R10");
      look(8'h30, 4'h0, 2'd0, "R10");

      // R4 and R5: every permission and dirty pattern against every access code
      for (int p = 0; p < 16; p++) begin
         fill(VW'(8'h50 + p), PW'(8'ha0 + p), 4'(p), 1'b0);
         for (int a = 0; a < 4; a++) look(VW'(8'h50 + p), PB'(a), 2'(a), (p[0] ? "R5" : "R4"));
      end

      // R11: write hit on a clean page leaves it clean
      fill(8'h77, 8'h12, 4'b1110, 1'b0);
      look(8'h77, 4'h3, 2'd1, "R11");
      look(8'h77, 4'h3, 2'd0, "R11");
      look(8'h77, 4'h3, 2'd1, "R11");

      finish_run();
   end
endmodule